// File: doc/BRIEF.md
# Gated Peripheral Clock Generator with Even Divider

This block produces one peripheral clock from a set of free-running source clocks. A select field chooses the source. The chosen clock either goes straight to the output or passes through a divider that gives an even ratio with a 50% duty cycle. An enable bit gates the output. The gate only opens or closes while the clock being gated is low, so the output never carries a shortened high pulse.

Control uses a register-style write port in the system clock domain. A single write strobe loads the enable bit, the divide enable, the division factor and the source select together. The enable readback stays high after a disable write until the output has actually stopped, and it drops only once that stop has been seen back in the system domain. A write that carries a new select, factor or divide enable while the readback is high is held back. It takes effect once the readback is low, so a running output never changes rate. A sleep input stops the output in the same glitch-free way and does not touch the enable bit. When sleep is released, the output starts again without software action.

Top module: `gclk_gen`

## Requirements
- R1: While reset is asserted, and in the system clock cycle after it, the output clock `gclk` is low and the readback `rd_en` is 0.
- R2: With divide enable set (`cfg_div_en`=1) and factor D on `cfg_div`, the output period is 2·(D+1) periods of the selected source, and the high time is (D+1) source periods.
- R3: With divide enable clear, the output follows the selected source clock, with the same period and high time.
- R4: A write with `cfg_en`=1 starts the output, and `rd_en` reads 1 in the system clock cycle after the write.
- R5: `cfg_sel`=k selects `src_clk[k]` as the source for both the divided and the undivided path.
- R6: A disable write stops the output only after a falling edge, and every high pulse has the full high time given by R2 or R3. No shortened pulse appears on the output.
- R7: After a write with `cfg_en`=0, `rd_en` still reads 1 in the next system cycle. It returns to 0 only after the last falling edge of `gclk`, and no output edge follows.
- R8: Select, factor and divide-enable values written while `rd_en`=1 do not change the running output. They take effect once `rd_en` reads 0.
- R9: While `sleep_req`=1 the output stops without a shortened pulse and `rd_en` stays 1. When `sleep_req` returns to 0, the output resumes at the programmed rate with no further write.
- R10: The first high pulse after enabling or waking has the full high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock for the control port |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of every clock |
| cfg_we | input | 1 | Write strobe for the control fields |
| cfg_en | input | 1 | Clock enable bit written |
| cfg_div_en | input | 1 | Divide enable written |
| cfg_div | input | 8 | Division factor D written, ratio 2·(D+1) |
| cfg_sel | input | 2 | Source select written |
| sleep_req | input | 1 | Sleep request, high forces the output off |
| src_clk | input | 4 | Source clocks, one bit per source |
| gclk | output | 1 | Gated, optionally divided, output clock |
| rd_en | output | 1 | Enable readback |

## Verification
The assertions rely on three things about the inputs. Select, factor and divide enable reach the source-domain logic only while the output is idle. The selected source toggles freely. Reset lasts long enough to clear the flops of every source domain. The stimulus meets these conditions in three ways. It holds reset for twenty system cycles. It changes configuration only through writes, which the block's hold logic defers until the readback is low. It always waits for the readback to reach zero before it re-enables with a new source or ratio. The bench times every output edge against free-running sources, each with its own period, and it tracks the shortest high pulse seen, so a shortened pulse at any stop shows up.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
    localparam int GC_NSRC = 4;
    localparam int GC_DIVW = 8;
    localparam int GC_SELW = (GC_NSRC > 1) ? $clog2(GC_NSRC) : 1;
    localparam int GC_SYNC_STAGES = 2;

    typedef struct packed {
        logic               div_en;
        logic [GC_DIVW-1:0] div;
        logic [GC_SELW-1:0] sel;
    } gc_cfg_t;

    localparam gc_cfg_t GC_CFG_RESET = '{div_en: 1'b0, div: '0, sel: '0};
endpackage

// File: rtl/gclk_sync.sv
module gclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
    import gclk_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  logic    wr_en,
    input  gc_cfg_t wr_cfg,
    input  logic    sleep_req,
    input  logic    busy_src,
    output gc_cfg_t cfg_q,
    output logic    run_q,
    output logic    rd_en
);
    logic    en_req;
    logic    ack;
    gc_cfg_t pend;
    logic    pend_v;

    gclk_sync #(.STAGES(GC_SYNC_STAGES)) u_ack_sync (
        .clk (clk),
        .rst (rst),
        .d   (busy_src),
        .q   (ack)
    );

    assign rd_en = en_req | ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_req <= 1'b0;
            run_q  <= 1'b0;
            cfg_q  <= GC_CFG_RESET;
            pend   <= GC_CFG_RESET;
            pend_v <= 1'b0;
        end else begin
            run_q <= en_req & ~sleep_req;
            if (we) begin
                en_req <= wr_en;
                if (rd_en) begin
                    pend   <= wr_cfg;
                    pend_v <= 1'b1;
                end else begin
                    cfg_q  <= wr_cfg;
                    pend_v <= 1'b0;
                end
            end else if (pend_v && !rd_en) begin
                cfg_q  <= pend;
                pend_v <= 1'b0;
            end
        end
    end

    // R8: applied configuration frozen while readback shows the clock alive
    p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> $stable(cfg_q))
        else $error("p_cfg_frozen_r8");
endmodule

// File: rtl/gclk_div.sv
module gclk_div
    import gclk_pkg::*;
(
    input  logic               clk_src,
    input  logic               rst,
    input  logic               run_a,
    input  logic               gate_on,
    input  logic [GC_DIVW-1:0] div,
    output logic               run_s,
    output logic               tog
);
    logic [GC_DIVW-1:0] cnt;

    gclk_sync #(.STAGES(GC_SYNC_STAGES)) u_run_sync (
        .clk (clk_src),
        .rst (rst),
        .d   (run_a),
        .q   (run_s)
    );

    always_ff @(posedge clk_src) begin
        if (rst || (!run_s && !gate_on)) begin
            cnt <= '0;
            tog <= 1'b0;
        end else if (cnt == div) begin
            cnt <= '0;
            tog <= ~tog;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: counter never passes the programmed factor
    p_cnt_bound_r2: assert property (@(posedge clk_src) disable iff (rst)
        cnt <= div)
        else $error("p_cnt_bound_r2");

    // R2: while gated on, the divided clock only flips at the terminal count
    p_tog_hold_r2: assert property (@(posedge clk_src) disable iff (rst)
        (gate_on && cnt != div) |=> $stable(tog))
        else $error("p_tog_hold_r2");
endmodule

// File: rtl/gclk_gate.sv
module gclk_gate (
    input  logic clk_src,
    input  logic rst,
    input  logic run_s,
    input  logic tog,
    input  logic div_en,
    output logic gate_on,
    output logic gclk
);
    logic pre_clk;

    assign pre_clk = div_en ? tog : clk_src;

    always_ff @(negedge clk_src) begin
        if (rst)                 gate_on <= 1'b0;
        else if (!div_en || !tog) gate_on <= run_s;
    end

    assign gclk = gate_on & pre_clk;

    // R6: in divided mode the gate opens or closes only while the divided clock is low
    p_gate_low_phase_r6: assert property (@(posedge clk_src) disable iff (rst)
        (div_en && ($rose(gate_on) || $fell(gate_on))) |-> !tog)
        else $error("p_gate_low_phase_r6");
endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
    import gclk_pkg::*;
(
    input  logic               clk_sys,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_en,
    input  logic               cfg_div_en,
    input  logic [GC_DIVW-1:0] cfg_div,
    input  logic [GC_SELW-1:0] cfg_sel,
    input  logic               sleep_req,
    input  logic [GC_NSRC-1:0] src_clk,
    output logic               gclk,
    output logic               rd_en
);
    gc_cfg_t wr_cfg;
    gc_cfg_t cfg_q;
    logic    run_q;
    logic    run_s;
    logic    tog;
    logic    gate_on;
    logic    clk_src;

    assign wr_cfg  = '{div_en: cfg_div_en, div: cfg_div, sel: cfg_sel};
    assign clk_src = src_clk[cfg_q.sel];

    gclk_ctrl u_ctrl (
        .clk       (clk_sys),
        .rst       (rst),
        .we        (cfg_we),
        .wr_en     (cfg_en),
        .wr_cfg    (wr_cfg),
        .sleep_req (sleep_req),
        .busy_src  (run_s | gate_on),
        .cfg_q     (cfg_q),
        .run_q     (run_q),
        .rd_en     (rd_en)
    );

    gclk_div u_div (
        .clk_src (clk_src),
        .rst     (rst),
        .run_a   (run_q),
        .gate_on (gate_on),
        .div     (cfg_q.div),
        .run_s   (run_s),
        .tog     (tog)
    );

    gclk_gate u_gate (
        .clk_src (clk_src),
        .rst     (rst),
        .run_s   (run_s),
        .tog     (tog),
        .div_en  (cfg_q.div_en),
        .gate_on (gate_on),
        .gclk    (gclk)
    );

    // R1: readback cleared by reset
    p_reset_clear_r1: assert property (@(posedge clk_sys)
        rst |=> !rd_en)
        else $error("p_reset_clear_r1");
endmodule

// File: tb/gclk_gen_tb.sv
`timescale 1ns/1ps
module gclk_gen_tb_top;
    import gclk_pkg::*;

    logic clk_sys = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0, cfg_en = 1'b0, cfg_div_en = 1'b0;
    logic [GC_DIVW-1:0] cfg_div = '0;
    logic [GC_SELW-1:0] cfg_sel = '0;
    logic sleep_req = 1'b0;
    logic [GC_NSRC-1:0] src_clk = '0;
    logic gclk, rd_en;

    int n_chk = 0;
    int n_err = 0;
    int ecnt = 0;
    realtime t_rise = 0.0;
    realtime t_fall = 0.0;
    realtime min_hi = 1.0e9;

    always #2.0 clk_sys = ~clk_sys;
    always #5.0 src_clk[0] = ~src_clk[0];
    always #3.0 src_clk[1] = ~src_clk[1];
    always #7.0 src_clk[2] = ~src_clk[2];
    always #4.0 src_clk[3] = ~src_clk[3];

    function automatic real half_of(input int sel);
        case (sel)
            0: return 5.0;
            1: return 3.0;
            2: return 7.0;
            default: return 4.0;
        endcase
    endfunction

    gclk_gen dut_i (
        .clk_sys (clk_sys), .rst (rst), .cfg_we (cfg_we), .cfg_en (cfg_en),
        .cfg_div_en (cfg_div_en), .cfg_div (cfg_div), .cfg_sel (cfg_sel),
        .sleep_req (sleep_req), .src_clk (src_clk), .gclk (gclk), .rd_en (rd_en)
    );

    always @(posedge gclk) begin
        ecnt++;
        t_rise = $realtime;
    end
    always @(negedge gclk) begin
        t_fall = $realtime;
        if (!rst && (t_fall - t_rise) < min_hi) min_hi = t_fall - t_rise;
    end

    task automatic chk(input bit ok, input string req, input real act, input real exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0.3f expected=%0.3f", req, act, exp);
        end
    endtask

    task automatic wr(input bit en, input bit den, input int div, input int sel);
        @(negedge clk_sys);
        cfg_we = 1'b1; cfg_en = en; cfg_div_en = den;
        cfg_div = GC_DIVW'(div); cfg_sel = GC_SELW'(sel);
        @(negedge clk_sys);
        cfg_we = 1'b0;
    endtask

    task automatic measure(output real per, output real hi);
        realtime a, b, c;
        @(posedge gclk); a = $realtime;
        @(negedge gclk); b = $realtime;
        @(posedge gclk); c = $realtime;
        per = c - a;
        hi = b - a;
    endtask

    task automatic wait_rd0(output realtime t0);
        t0 = -1.0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk_sys);
            if (!rd_en) begin
                t0 = $realtime;
                break;
            end
        end
    endtask

    function automatic bit near(input real a, input real b);
        return (a > b - 0.01) && (a < b + 0.01);
    endfunction

    task automatic t_reset();
        #1;
        chk(gclk == 1'b0, "R1 gclk in reset", real'(gclk), 0.0);
        chk(rd_en == 1'b0, "R1 rd_en in reset", real'(rd_en), 0.0);
        repeat (20) @(negedge clk_sys);
        rst = 1'b0;
        @(negedge clk_sys);
        chk(rd_en == 1'b0, "R1 rd_en after reset", real'(rd_en), 0.0);
        chk(gclk == 1'b0, "R1 gclk after reset", real'(gclk), 0.0);
    endtask

    task automatic t_stop();
        realtime t0;
        int e0;
        wr(0, 0, 0, 0);
        wait_rd0(t0);
        chk(t0 >= 0.0, "R7 readback reaches zero", t0, 0.0);
        e0 = ecnt;
        #300;
        chk(ecnt == e0, "R7 no edge after readback zero", real'(ecnt - e0), 0.0);
    endtask

    task automatic t_undiv();
        real per, hi;
        wr(1, 0, 0, 0);
        chk(rd_en == 1'b1, "R4 readback after enable", real'(rd_en), 1.0);
        measure(per, hi);
        chk(near(per, 10.0), "R3 undivided period src0", per, 10.0);
        chk(near(hi, 5.0), "R3 undivided high src0", hi, 5.0);
        t_stop();
        wr(1, 0, 0, 2);
        measure(per, hi);
        chk(near(per, 14.0), "R5 undivided period src2", per, 14.0);
        t_stop();
    endtask

    task automatic t_div(input int sel, input int d);
        real per, hi, exp_p;
        exp_p = 4.0 * half_of(sel) * real'(d + 1);
        wr(1, 1, d, sel);
        measure(per, hi);
        chk(near(per, exp_p), "R2 divided period", per, exp_p);
        chk(near(hi, exp_p / 2.0), "R2 divided high time", hi, exp_p / 2.0);
        t_stop();
    endtask

    task automatic t_first_pulse();
        realtime a, b;
        min_hi = 1.0e9;
        wr(1, 1, 2, 3);
        @(posedge gclk); a = $realtime;
        @(negedge gclk); b = $realtime;
        chk(near(b - a, 24.0), "R10 first high pulse", b - a, 24.0);
        t_stop();
    endtask

    task automatic t_disable();
        realtime t0;
        int e0;
        min_hi = 1.0e9;
        wr(1, 1, 9, 0);
        @(posedge gclk);
        @(posedge gclk);
        #20;
        @(negedge clk_sys);
        cfg_we = 1'b1; cfg_en = 1'b0;
        @(negedge clk_sys);
        cfg_we = 1'b0;
        chk(rd_en == 1'b1, "R7 readback held after disable write", real'(rd_en), 1.0);
        wait_rd0(t0);
        chk(t0 >= 0.0 && t_fall < t0, "R7 last fall precedes readback zero", t_fall, t0);
        chk(min_hi > 99.99, "R6 no short pulse at disable", min_hi, 100.0);
        e0 = ecnt;
        #400;
        chk(ecnt == e0, "R6 output stays off", real'(ecnt - e0), 0.0);
    endtask

    task automatic t_hold();
        real per, hi;
        realtime t0;
        wr(1, 1, 1, 0);
        measure(per, hi);
        wr(1, 1, 3, 1);
        measure(per, hi);
        chk(near(per, 40.0), "R8 running rate unchanged by write", per, 40.0);
        wr(0, 1, 3, 1);
        wait_rd0(t0);
        wr(1, 1, 3, 1);
        measure(per, hi);
        chk(near(per, 48.0), "R8 held setting applied", per, 48.0);
        t_stop();
    endtask

    task automatic t_sleep();
        real per, hi;
        int e0;
        min_hi = 1.0e9;
        wr(1, 0, 0, 3);
        measure(per, hi);
        sleep_req = 1'b1;
        #200;
        e0 = ecnt;
        #200;
        chk(ecnt == e0, "R9 output off in sleep", real'(ecnt - e0), 0.0);
        chk(rd_en == 1'b1, "R9 readback kept in sleep", real'(rd_en), 1.0);
        chk(min_hi > 3.99, "R9 no short pulse on sleep", min_hi, 4.0);
        sleep_req = 1'b0;
        measure(per, hi);
        chk(near(per, 8.0), "R9 resumes after wake", per, 8.0);
        chk(near(hi, 4.0), "R10 full high after wake", hi, 4.0);
        t_stop();
    endtask

    initial begin
        t_reset();
        t_undiv();
        t_div(1, 0);
        t_div(0, 4);
        t_div(3, 255);
        t_first_pulse();
        t_disable();
        t_hold();
        t_sleep();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400us;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule